// File: doc/BRIEF.md
# Rearmable Watchdog Timer

This block is a single-channel watchdog. A down-counter loses one count on every base-clock cycle while the watchdog runs, and a grant output stays high for as long as it runs. Software keeps the watchdog alive by writing a fresh preset into the counter register before the count runs out. If the count reaches zero and is not reloaded, the watchdog fires and grant drops. The complementary output rises at the same moment.

Once fired, the watchdog stays in the timed-out state. Writing the counter again changes the stored count but does not restart it. Software restarts it by writing 1 to a rearm bit, which clears itself. After reset the block is in the fired state with a count of zero. The intended start-up order is therefore: load the preset, then rearm. A small register window gives access to the status, the configuration, the channel count, a constant holding the base clock frequency, and the live counter.

Top module: `wdog_rearm`

## Requirements
- R1: After reset, grant_o is 0, grant_n_o is 1, the counter (offset 0x24) reads 0 and status bit 0 (offset 0x10) reads 0.
- R2: A write to offset 0x24 loads the written value into the counter at that clock edge. A read of 0x24 returns the current count, not the last value written.
- R3: While the watchdog runs with a nonzero count and no counter write, the count drops by exactly one per cycle.
- R4: While the watchdog runs with a count of 0 and no counter write, grant_o is 0 after the next edge and the count stays 0. After a rearm with preset N, grant_o stays high for N+1 cycles.
- R5: While fired, a counter write updates the stored value. The count then holds, and grant_o stays 0 until a rearm.
- R6: Writing 1 to bit 0 of offset 0x14 while fired sets grant_o at that edge and keeps the stored count. Offset 0x14 always reads 0.
- R7: A rearm while running changes neither grant_o nor the count sequence. Writing 0 to bit 0 of 0x14 while fired leaves grant_o at 0.
- R8: A counter write in the same cycle as expiry (running with a count of 0) wins. grant_o stays 1 and the count takes the written value.
- R9: Offset 0x20 reads the BASE_CLK_HZ parameter, and offset 0x18 reads 1. Writes to either are ignored. Unmapped offsets read 0.
- R10: grant_n_o is always the complement of grant_o.
- R11: Status bit 0 equals grant_o, and the other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; the counter steps on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| grant_o | output | 1 | High while the watchdog runs |
| grant_n_o | output | 1 | Complement of grant_o |

## Verification
A counter reload and the expiry of the count can fall in the same cycle. Which of them takes effect decides whether the system keeps its grant. The bench rearms with a short preset and counts the cycles down until the counter reads zero. It then issues the reload write in exactly that cycle. It expects grant to stay high, the counter to show the new value, and the value to fall by one on the following cycle. It also sweeps every preset from 0 to 12 to pin down the N+1 grant length at the other edge of that race.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    // Byte offsets inside the register window
    localparam int unsigned OFF_STATUS   = 32'h10;
    localparam int unsigned OFF_CONFIG   = 32'h14;
    localparam int unsigned OFF_CHANNELS = 32'h18;
    localparam int unsigned OFF_BASECLK  = 32'h20;
    localparam int unsigned OFF_COUNT    = 32'h24;

    // Bit positions software relies on
    localparam int unsigned BIT_RUNNING = 0;
    localparam int unsigned BIT_REARM   = 0;

    localparam int unsigned NUM_CHANNELS = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CONFIG,
        SEL_CHANNELS,
        SEL_BASECLK,
        SEL_COUNT
    } reg_sel_e;

endpackage

// File: rtl/wdog_decode.sv
`timescale 1ns/1ps
module wdog_decode
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned BASE_CLK_HZ = 100_000_000
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              running,
    input  logic [CNT_W-1:0]  count,
    output logic              load_cnt,
    output logic [CNT_W-1:0]  load_val,
    output logic              rearm,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_sel_e sel;

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_STATUS):   sel = SEL_STATUS;
            ADDR_W'(OFF_CONFIG):   sel = SEL_CONFIG;
            ADDR_W'(OFF_CHANNELS): sel = SEL_CHANNELS;
            ADDR_W'(OFF_BASECLK):  sel = SEL_BASECLK;
            ADDR_W'(OFF_COUNT):    sel = SEL_COUNT;
            default:               sel = SEL_NONE;
        endcase
    end

    // Write strobes toward the core; constant words ignore writes
    always_comb begin
        load_cnt = bus_wr && (sel == SEL_COUNT);
        load_val = bus_wdata[CNT_W-1:0];
        rearm    = bus_wr && (sel == SEL_CONFIG) && bus_wdata[BIT_REARM];
    end

    // Read mux; the rearm bit self-clears, so config reads zero
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_STATUS:   bus_rdata[BIT_RUNNING] = running;
            SEL_CHANNELS: bus_rdata = DATA_W'(NUM_CHANNELS);
            SEL_BASECLK:  bus_rdata = DATA_W'(BASE_CLK_HZ);
            SEL_COUNT:    bus_rdata = DATA_W'(count);
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_cnt,
    input  logic [CNT_W-1:0] load_val,
    input  logic             rearm,
    output logic             running,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] count;
    } wd_state_t;

    wd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_cnt) begin
            // reload beats expiry; run state unchanged
            st_d.count = load_val;
        end else if (st_q.running) begin
            if (st_q.count == '0) begin
                st_d.running = 1'b0;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end else if (rearm) begin
            st_d.running = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.running;
    assign count   = st_q.count;

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load_cnt && count != '0) |=> (running && count == $past(count) - CNT_W'(1))); // R3
    AST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load_cnt && count == '0) |=> (!running && count == '0)); // R4
    AST_FIRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load_cnt && !rearm) |=> (!running && $stable(count))); // R5
    AST_REARM_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && rearm && !load_cnt) |=> (running && $stable(count))); // R6
    AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && load_cnt) |=> (running && count == $past(load_val))); // R8

endmodule

// File: rtl/wdog_rearm.sv
`timescale 1ns/1ps
module wdog_rearm #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned BASE_CLK_HZ = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              grant_o,
    output logic              grant_n_o
);

    logic             load_cnt;
    logic [CNT_W-1:0] load_val;
    logic             rearm;
    logic             running;
    logic [CNT_W-1:0] count;

    wdog_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .BASE_CLK_HZ(BASE_CLK_HZ)
    ) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .running  (running),
        .count    (count),
        .load_cnt (load_cnt),
        .load_val (load_val),
        .rearm    (rearm),
        .bus_rdata(bus_rdata)
    );

    wdog_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_cnt(load_cnt),
        .load_val(load_val),
        .rearm   (rearm),
        .running (running),
        .count   (count)
    );

    assign grant_o   = running;
    assign grant_n_o = ~running;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (count == $past(bus_wdata[CNT_W-1:0]))); // R2

endmodule

// File: tb/wdog_rearm_test.sv
`timescale 1ns/1ps
module wdog_rearm_test;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BASE   = 100_000_000;
    localparam logic [7:0] A_STAT = 8'h10, A_CFG = 8'h14, A_CHN = 8'h18,
                           A_BASE = 8'h20, A_CNT = 8'h24, A_NONE = 8'h30;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              grant_o, grant_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wdog_rearm uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grant_o(grant_o), .grant_n_o(grant_n_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write takes effect on the next rising edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // checks grant, its complement (R10) and status (R11), plus the count
    task automatic expect_state(string req, logic g, logic [31:0] c);
        logic [31:0] v;
        check(req, {31'd0, grant_o}, {31'd0, g});
        check("R10", {31'd0, grant_n_o}, {31'd0, ~g});
        rd(A_STAT, v);
        check("R11", v, {31'd0, g});
        rd(A_CNT, v);
        check(req, v, c);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_state("R1", 1'b0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_state("R1", 1'b0, 32'd0);

        // R9 constants and unmapped read
        rd(A_BASE, v); check("R9", v, BASE);
        rd(A_CHN, v);  check("R9", v, 32'd1);
        rd(A_NONE, v); check("R9", v, 32'd0);
        wr(A_BASE, 32'h1234);
        wr(A_CHN, 32'h7);
        rd(A_BASE, v); check("R9", v, BASE);
        rd(A_CHN, v);  check("R9", v, 32'd1);

        // R7: writing 0 to rearm while fired has no effect
        wr(A_CFG, 32'd0);
        expect_state("R7", 1'b0, 32'd0);

        // Sweep presets: load while fired (R5), rearm (R6), count down (R3), fire (R4)
        for (int n = 0; n <= 12; n++) begin
            wr(A_CNT, n);
            expect_state("R2", 1'b0, n);
            repeat (3) @(negedge clk);
            expect_state("R5", 1'b0, n);
            wr(A_CFG, 32'd1);
            expect_state("R6", 1'b1, n);
            rd(A_CFG, v); check("R6", v, 32'd0);
            for (int k = 1; k <= n; k++) begin
                @(negedge clk);
                expect_state("R3", 1'b1, n - k);
            end
            @(negedge clk);
            expect_state("R4", 1'b0, 32'd0);
            @(negedge clk);
            expect_state("R4", 1'b0, 32'd0);
        end

        // R8: reload in the expiry cycle
        wr(A_CNT, 32'd3);
        wr(A_CFG, 32'd1);
        repeat (3) @(negedge clk);
        expect_state("R8", 1'b1, 32'd0);
        wr(A_CNT, 32'd5);
        expect_state("R8", 1'b1, 32'd5);
        @(negedge clk);
        expect_state("R8", 1'b1, 32'd4);

        // R7: rearm while running leaves the sequence alone
        wr(A_CFG, 32'd1);
        expect_state("R7", 1'b1, 32'd3);
        @(negedge clk);
        expect_state("R7", 1'b1, 32'd2);

        // R2: reload while running, read shows the live count
        wr(A_CNT, 32'h0000_1000);
        expect_state("R2", 1'b1, 32'h0000_1000);
        repeat (4) @(negedge clk);
        expect_state("R2", 1'b1, 32'h0000_0FFC);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule